// File: doc/BRIEF.md
# Byte-Lane True Dual-Port Memory

This block is a synchronous memory with two fully independent access ports, A and B. Each port has its own clock, reset, enable, per-lane write enables, address, write data and read data. A stored word is split into lanes of nine bits: eight data bits plus one spare bit. The spare bit is plain storage and carries no parity meaning. Any port may write any subset of lanes while the other port reads or writes elsewhere in the array.

Every write also produces read data. The word returned during a write depends on the write mode, which is chosen per port by a parameter. Read-first returns the word as it was before the write. Write-first returns the word as it is after the write: the new lanes, with the untouched lanes showing their stored values. No-change leaves the output as it was. A parameter adds a second output register per port, which lengthens read latency from one cycle to two. The synchronous reset of a port clears only that port's output registers. The stored words are never cleared.

Two ports on the same address in the same cycle, with at least one of them writing, give undefined results. The block raises a per-port collision flag one cycle later so that such events can be caught. Inside, each port owns a private bank. A small table of lane tags, combined by XOR, records which bank holds the newest copy of each lane. As a result, no storage element has more than one writer.

Top module: `lane_tdp_ram`

## Requirements
- R1: A word written through either port can be read back through either port, and the two ports may perform accesses at different addresses in the same cycle.
- R2: Write-enable bit k of a port writes lane k, which is word bits [9k+8:9k] including the spare bit 9k+8. Lanes whose enable is low keep their stored value.
- R3: On a write-first port, the output after a write equals the full word now stored: written lanes carry the new data and unwritten lanes carry the stored data.
- R4: On a read-first port, the output after a write equals the word stored before that write.
- R5: On a no-change port, the output keeps its previous value across a cycle in which the port writes.
- R6: While a port's enable is low, that port writes nothing and its output registers hold, whatever its write enables, address and data show.
- R7: Read data appears one clock after the access when the port has no output pipeline, and two clocks after it when the pipeline register is enabled.
- R8: Holding a port's reset high at a clock edge clears that port's output registers to zero, and the memory contents stay unchanged.
- R9: A port's collision flag is high for the one cycle after an edge at which both ports were enabled on the same address with at least one write enable set. It is low otherwise and after reset.
- R10: An enabled access with all write enables low returns the stored word, whatever the port's write mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A synchronous reset of output registers |
| en_a | input | 1 | Port A enable |
| we_a | input | LANES | Port A per-lane write enables |
| addr_a | input | $clog2(DEPTH) | Port A word address |
| din_a | input | LANES*9 | Port A write data |
| dout_a | output | LANES*9 | Port A read data |
| coll_a | output | 1 | Port A collision flag, in clk_a domain |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B synchronous reset of output registers |
| en_b | input | 1 | Port B enable |
| we_b | input | LANES | Port B per-lane write enables |
| addr_b | input | $clog2(DEPTH) | Port B word address |
| din_b | input | LANES*9 | Port B write data |
| dout_b | output | LANES*9 | Port B read data |
| coll_b | output | 1 | Port B collision flag, in clk_b domain |

## Verification
The hardest case to reach is a lane whose newest copy sits in the other port's bank while the reading port's own bank holds a stale copy for the same word. It needs interleaved partial writes from both ports to one address over several cycles, followed by a write-first partial write on top. The stimulus lays down whole words from both ports, then partial writes with opposite lane masks from each side on shared addresses. A long pseudo-random phase follows on a 32-word window so that addresses are reused often. Two instances with different mode and pipeline settings receive the same inputs, so all three write modes and both latencies are compared against one behavioural model on every clock.

// File: rtl/tdpr_pkg.sv
package tdpr_pkg;

    typedef enum logic [1:0] {
        WM_READ_FIRST  = 2'd0,
        WM_WRITE_FIRST = 2'd1,
        WM_NO_CHANGE   = 2'd2
    } wmode_e;

    localparam int SPARE_BITS = 1;

endpackage

// File: rtl/tdpr_bank.sv
// One port's private storage bank plus its lane-tag table.
// Written only from its own clock; read combinationally at both addresses.
module tdpr_bank #(
    parameter int DEPTH     = 512,
    parameter int LANES     = 4,
    parameter int LANE_W    = 9,
    parameter bit INVERT    = 1'b0,
    localparam int AW       = $clog2(DEPTH),
    localparam int W        = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             en,
    input  logic [LANES-1:0] we,
    input  logic [AW-1:0]    addr,
    input  logic [W-1:0]     wr_data,
    input  logic [LANES-1:0] peer_tag_here,
    input  logic [AW-1:0]    peer_addr,
    output logic [W-1:0]     own_data,
    output logic [LANES-1:0] own_tag,
    output logic [W-1:0]     peer_side_data,
    output logic [LANES-1:0] peer_side_tag
);

    logic [W-1:0]     data_q [DEPTH];
    logic [LANES-1:0] tag_q  [DEPTH];

    // A write marks each written lane as newest here: the tag pair XOR
    // becomes 0 for the non-inverting bank and 1 for the inverting one.
    always_ff @(posedge clk) begin
        if (en) begin
            for (int l = 0; l < LANES; l++) begin
                if (we[l]) begin
                    data_q[addr][l*LANE_W +: LANE_W] <= wr_data[l*LANE_W +: LANE_W];
                    tag_q[addr][l] <= peer_tag_here[l] ^ INVERT;
                end
            end
        end
    end

    assign own_data       = data_q[addr];
    assign own_tag        = tag_q[addr];
    assign peer_side_data = data_q[peer_addr];
    assign peer_side_tag  = tag_q[peer_addr];

endmodule

// File: rtl/tdpr_rdport.sv
// Lane selection between banks, write-mode output choice and output registers.
module tdpr_rdport #(
    parameter int              LANES  = 4,
    parameter int              LANE_W = 9,
    parameter bit              INVERT = 1'b0,
    parameter tdpr_pkg::wmode_e MODE  = tdpr_pkg::WM_WRITE_FIRST,
    parameter bit              PIPE   = 1'b0,
    localparam int W = LANES * LANE_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [LANES-1:0] we,
    input  logic [W-1:0]     wr_data,
    input  logic [W-1:0]     mine_data,
    input  logic [LANES-1:0] mine_tag,
    input  logic [W-1:0]     peer_data,
    input  logic [LANES-1:0] peer_tag,
    output logic [W-1:0]     dout
);

    logic [W-1:0] cur_word;
    logic [W-1:0] wf_word;
    logic [W-1:0] next_q1;
    logic [W-1:0] stage1_q;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        logic use_peer;
        assign use_peer = mine_tag[l] ^ peer_tag[l] ^ INVERT;
        assign cur_word[l*LANE_W +: LANE_W] =
            use_peer ? peer_data[l*LANE_W +: LANE_W] : mine_data[l*LANE_W +: LANE_W];
        assign wf_word[l*LANE_W +: LANE_W] =
            we[l] ? wr_data[l*LANE_W +: LANE_W] : cur_word[l*LANE_W +: LANE_W];
    end

    always_comb begin
        next_q1 = stage1_q;
        if (en) begin
            if (we == '0) begin
                next_q1 = cur_word;
            end else begin
                unique case (MODE)
                    tdpr_pkg::WM_READ_FIRST:  next_q1 = cur_word;
                    tdpr_pkg::WM_WRITE_FIRST: next_q1 = wf_word;
                    tdpr_pkg::WM_NO_CHANGE:   next_q1 = stage1_q;
                    default:                  next_q1 = stage1_q;
                endcase
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) stage1_q <= '0;
        else     stage1_q <= next_q1;
    end

    if (PIPE) begin : g_pipe
        logic [W-1:0] stage2_q;
        always_ff @(posedge clk) begin
            if (rst) stage2_q <= '0;
            else     stage2_q <= stage1_q;
        end
        assign dout = stage2_q;

        assert_pipe_delay_R7: assert property (@(posedge clk) disable iff (rst)
            !rst |=> dout == $past(stage1_q));
    end else begin : g_nopipe
        assign dout = stage1_q;
    end

    assert_reset_clears_R8: assert property (@(posedge clk)
        rst |=> stage1_q == '0);

    assert_idle_holds_R6: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(stage1_q));

    if (MODE == tdpr_pkg::WM_NO_CHANGE) begin : g_nc_chk
        assert_nochange_hold_R5: assert property (@(posedge clk) disable iff (rst)
            (en && (we != '0)) |=> $stable(stage1_q));
    end

    if (MODE == tdpr_pkg::WM_WRITE_FIRST) begin : g_wf_chk
        assert_wf_full_word_R3: assert property (@(posedge clk) disable iff (rst)
            (en && (&we)) |=> stage1_q == $past(wr_data));
    end

endmodule

// File: rtl/lane_tdp_ram.sv
module lane_tdp_ram #(
    parameter int               DEPTH     = 512,
    parameter int               LANES     = 4,
    parameter int               DATA_BITS = 8,
    parameter tdpr_pkg::wmode_e MODE_A    = tdpr_pkg::WM_WRITE_FIRST,
    parameter tdpr_pkg::wmode_e MODE_B    = tdpr_pkg::WM_WRITE_FIRST,
    parameter bit               PIPE_A    = 1'b0,
    parameter bit               PIPE_B    = 1'b0,
    localparam int AW     = $clog2(DEPTH),
    localparam int LANE_W = DATA_BITS + tdpr_pkg::SPARE_BITS,
    localparam int W      = LANES * LANE_W
) (
    input  logic             clk_a,
    input  logic             rst_a,
    input  logic             en_a,
    input  logic [LANES-1:0] we_a,
    input  logic [AW-1:0]    addr_a,
    input  logic [W-1:0]     din_a,
    output logic [W-1:0]     dout_a,
    output logic             coll_a,
    input  logic             clk_b,
    input  logic             rst_b,
    input  logic             en_b,
    input  logic [LANES-1:0] we_b,
    input  logic [AW-1:0]    addr_b,
    input  logic [W-1:0]     din_b,
    output logic [W-1:0]     dout_b,
    output logic             coll_b
);

    logic [W-1:0]     a_own_data, a_at_b_data, b_own_data, b_at_a_data;
    logic [LANES-1:0] a_own_tag,  a_at_b_tag,  b_own_tag,  b_at_a_tag;
    logic             hit;

    tdpr_bank #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .INVERT(1'b0)) u_bank_a (
        .clk(clk_a), .en(en_a), .we(we_a), .addr(addr_a), .wr_data(din_a),
        .peer_tag_here(b_at_a_tag), .peer_addr(addr_b),
        .own_data(a_own_data), .own_tag(a_own_tag),
        .peer_side_data(a_at_b_data), .peer_side_tag(a_at_b_tag)
    );

    tdpr_bank #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W), .INVERT(1'b1)) u_bank_b (
        .clk(clk_b), .en(en_b), .we(we_b), .addr(addr_b), .wr_data(din_b),
        .peer_tag_here(a_at_b_tag), .peer_addr(addr_a),
        .own_data(b_own_data), .own_tag(b_own_tag),
        .peer_side_data(b_at_a_data), .peer_side_tag(b_at_a_tag)
    );

    tdpr_rdport #(.LANES(LANES), .LANE_W(LANE_W), .INVERT(1'b0),
                  .MODE(MODE_A), .PIPE(PIPE_A)) u_rd_a (
        .clk(clk_a), .rst(rst_a), .en(en_a), .we(we_a), .wr_data(din_a),
        .mine_data(a_own_data), .mine_tag(a_own_tag),
        .peer_data(b_at_a_data), .peer_tag(b_at_a_tag),
        .dout(dout_a)
    );

    tdpr_rdport #(.LANES(LANES), .LANE_W(LANE_W), .INVERT(1'b1),
                  .MODE(MODE_B), .PIPE(PIPE_B)) u_rd_b (
        .clk(clk_b), .rst(rst_b), .en(en_b), .we(we_b), .wr_data(din_b),
        .mine_data(b_own_data), .mine_tag(b_own_tag),
        .peer_data(a_at_b_data), .peer_tag(a_at_b_tag),
        .dout(dout_b)
    );

    assign hit = en_a && en_b && (addr_a == addr_b) && ((we_a != '0) || (we_b != '0));

    always_ff @(posedge clk_a) begin
        if (rst_a) coll_a <= 1'b0;
        else       coll_a <= hit;
    end

    always_ff @(posedge clk_b) begin
        if (rst_b) coll_b <= 1'b0;
        else       coll_b <= hit;
    end

    assert_flag_needs_peer_R9: assert property (@(posedge clk_a) disable iff (rst_a)
        !en_b |=> !coll_a);

    assert_flag_needs_self_R9: assert property (@(posedge clk_b) disable iff (rst_b)
        !en_a |=> !coll_b);

endmodule

// File: tb/lane_tdp_ram_test.sv
module lane_tdp_ram_test;

    localparam int W = 36;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en_a = 1'b0, en_b = 1'b0;
    logic [3:0]  we_a = '0, we_b = '0;
    logic [8:0]  addr_a = '0, addr_b = '0;
    logic [W-1:0] din_a = '0, din_b = '0;
    logic [W-1:0] dout_a, dout_b, dout_a2, dout_b2;
    logic        coll_a, coll_b, coll_a2, coll_b2;

    always #5 clk = ~clk;

    // uut: A write-first no pipe, B read-first with pipe
    lane_tdp_ram #(.MODE_A(tdpr_pkg::WM_WRITE_FIRST), .PIPE_A(1'b0),
                   .MODE_B(tdpr_pkg::WM_READ_FIRST),  .PIPE_B(1'b1)) uut (
        .clk_a(clk), .rst_a(rst), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dout_a(dout_a), .coll_a(coll_a),
        .clk_b(clk), .rst_b(rst), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .dout_b(dout_b), .coll_b(coll_b));

    // uut_nc: A no-change with pipe, B write-first no pipe
    lane_tdp_ram #(.MODE_A(tdpr_pkg::WM_NO_CHANGE),   .PIPE_A(1'b1),
                   .MODE_B(tdpr_pkg::WM_WRITE_FIRST), .PIPE_B(1'b0)) uut_nc (
        .clk_a(clk), .rst_a(rst), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dout_a(dout_a2), .coll_a(coll_a2),
        .clk_b(clk), .rst_b(rst), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .dout_b(dout_b2), .coll_b(coll_b2));

    // ---------------- reference model ----------------
    // mode codes: 0 read-first, 1 write-first, 2 no-change
    int md [4] = '{1, 0, 2, 1};
    bit pp [4] = '{1'b0, 1'b1, 1'b1, 1'b0};
    logic [W-1:0] mem [32];
    logic [W-1:0] e1 [4], e2 [4];
    bit v1 [4], v2 [4];
    logic ecoll = 1'b0;

    function automatic logic [W-1:0] merge(logic [3:0] we, logic [W-1:0] d, logic [W-1:0] w);
        logic [W-1:0] r = w;
        for (int l = 0; l < 4; l++) if (we[l]) r[l*9 +: 9] = d[l*9 +: 9];
        return r;
    endfunction

    function automatic logic [W-1:0] nextv(int m, bit en, logic [3:0] we,
                                           logic [W-1:0] d, logic [W-1:0] w, logic [W-1:0] q);
        if (!en) return q;
        if (we == 4'h0) return w;
        if (m == 1) return merge(we, d, w);
        if (m == 2) return q;
        return w;
    endfunction

    logic [W-1:0] ra, rb;
    bit cl;
    always @(posedge clk) begin
        ra = mem[addr_a[4:0]];
        rb = mem[addr_b[4:0]];
        cl = en_a && en_b && (addr_a == addr_b) && ((we_a != 0) || (we_b != 0));
        for (int p = 0; p < 4; p++) begin
            if (rst) begin
                e2[p] = '0; v2[p] = 1'b1; e1[p] = '0; v1[p] = 1'b1;
            end else begin
                e2[p] = e1[p]; v2[p] = v1[p];
                if (p % 2 == 0) begin
                    e1[p] = nextv(md[p], en_a, we_a, din_a, ra, e1[p]);
                    if (en_a) v1[p] = !cl;
                end else begin
                    e1[p] = nextv(md[p], en_b, we_b, din_b, rb, e1[p]);
                    if (en_b) v1[p] = !cl;
                end
            end
        end
        ecoll = rst ? 1'b0 : cl;
        if (en_a) mem[addr_a[4:0]] = merge(we_a, din_a, ra);
        if (en_b) mem[addr_b[4:0]] = merge(we_b, din_b, mem[addr_b[4:0]]);
    end

    // ---------------- checking ----------------
    int checks = 0, errors = 0;
    string phase = "R8";
    bit done = 1'b0;

    task automatic check(bit ok, string what, logic [W-1:0] act, logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", phase, what, act, exp, $time);
        end
    endtask

    task automatic cmp_all();
        logic [W-1:0] act [4];
        logic [W-1:0] ex;
        bit vv;
        act[0] = dout_a; act[1] = dout_b; act[2] = dout_a2; act[3] = dout_b2;
        for (int p = 0; p < 4; p++) begin
            ex = pp[p] ? e2[p] : e1[p];
            vv = pp[p] ? v2[p] : v1[p];
            if (vv) check(act[p] === ex, $sformatf("dout[%0d]", p), act[p], ex);
        end
        check(coll_a === ecoll,  "coll_a",    W'(coll_a),  W'(ecoll));
        check(coll_b === ecoll,  "coll_b",    W'(coll_b),  W'(ecoll));
        check(coll_a2 === ecoll, "coll_a_nc", W'(coll_a2), W'(ecoll));
        check(coll_b2 === ecoll, "coll_b_nc", W'(coll_b2), W'(ecoll));
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
        cmp_all();
    endtask

    task automatic drive(bit ea, logic [3:0] wa, int aa, logic [W-1:0] da,
                         bit eb, logic [3:0] wb, int ab, logic [W-1:0] db);
        en_a = ea; we_a = wa; addr_a = 9'(aa); din_a = da;
        en_b = eb; we_b = wb; addr_b = 9'(ab); din_b = db;
        tick();
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            checks++; errors++;
            $display("FAIL watchdog expired in phase %s", phase);
            summary();
            $finish;
        end
    end

    initial begin
        logic [31:0] s;
        // R8: reset state of all outputs
        phase = "R8";
        repeat (3) tick();
        rst = 1'b0;

        // R1: fill the window from both ports, then cross-read
        phase = "R1";
        for (int i = 0; i < 32; i++)
            drive(1, 4'hF, i, 36'h1_3579_BDF0 ^ (W'(i) * 36'h0_0101_0107),
                  1, 4'hF, (i + 16) % 32, 36'h8_2468_ACE1 ^ (W'(i) * 36'h0_0203_0405));
        for (int i = 0; i < 8; i++) drive(1, 4'h0, i * 3, '0, 1, 4'h0, 31 - i * 2, '0);

        // R2: lane enables incl. spare bits, opposite masks from each side
        phase = "R2";
        drive(1, 4'b0101, 4, 36'hF_FFFF_FFFF, 1, 4'b1010, 7, 36'h8_0602_0100);
        drive(1, 4'b1010, 7, 36'h9_5555_AAAA, 1, 4'b0101, 4, 36'h1_0000_0000);
        drive(1, 4'h0, 7, '0, 1, 4'h0, 4, '0);
        drive(1, 4'h0, 4, '0, 1, 4'h0, 7, '0);

        // R3: partial write-first writes on words last written by the peer
        phase = "R3";
        drive(1, 4'b0011, 20, 36'hA_BCDE_F012, 1, 4'b1100, 21, 36'h3_1415_9265);
        drive(1, 4'b1000, 21, 36'h7_7777_7777, 1, 4'b0001, 20, 36'h0_0000_01FF);
        drive(1, 4'hF, 22, 36'h5_A5A5_A5A5, 1, 4'hF, 23, 36'hC_3C3C_3C3C);

        // R4: read-first on port B of uut
        phase = "R4";
        drive(0, 4'h0, 0, '0, 1, 4'b0110, 20, 36'h6_0000_0000);
        drive(0, 4'h0, 0, '0, 1, 4'hF, 21, 36'h0_DEAD_BEEF);
        drive(0, 4'h0, 0, '0, 1, 4'h0, 21, '0);

        // R5: no-change on port A of uut_nc
        phase = "R5";
        drive(1, 4'h0, 9, '0, 0, 4'h0, 0, '0);
        drive(1, 4'hF, 10, 36'h2_2222_2222, 0, 4'h0, 0, '0);
        drive(1, 4'b0001, 11, 36'h0_0000_0133, 0, 4'h0, 0, '0);
        drive(1, 4'h0, 10, '0, 0, 4'h0, 0, '0);

        // R6: disabled ports ignore write enables and data
        phase = "R6";
        drive(0, 4'hF, 4, 36'h0_0BAD_0BAD, 0, 4'hF, 7, 36'h0_0BAD_0BAD);
        drive(0, 4'hF, 9, 36'h0_1111_1111, 0, 4'h3, 10, 36'h0_2222_2222);
        drive(1, 4'h0, 4, '0, 1, 4'h0, 7, '0);
        drive(1, 4'h0, 10, '0, 1, 4'h0, 9, '0);

        // R7: back-to-back reads reveal both latencies
        phase = "R7";
        for (int i = 0; i < 6; i++) drive(1, 4'h0, i, '0, 1, 4'h0, 31 - i, '0);

        // R8: mid-run reset keeps contents
        phase = "R8";
        drive(1, 4'h0, 3, '0, 1, 4'h0, 5, '0);
        rst = 1'b1;
        drive(1, 4'h0, 3, '0, 1, 4'h0, 5, '0);
        drive(0, 4'h0, 3, '0, 0, 4'h0, 5, '0);
        rst = 1'b0;
        drive(1, 4'h0, 3, '0, 1, 4'h0, 5, '0);
        drive(1, 4'h0, 5, '0, 1, 4'h0, 3, '0);

        // R9: collision flag
        phase = "R9";
        drive(1, 4'hF, 12, 36'h4_4444_4444, 1, 4'h0, 12, '0);
        drive(1, 4'h0, 12, '0, 1, 4'h0, 13, '0);
        drive(1, 4'h0, 13, '0, 1, 4'b0100, 13, 36'h0_00AB_0000);
        drive(1, 4'h0, 13, '0, 1, 4'h0, 13, '0);
        drive(1, 4'h0, 12, '0, 1, 4'h0, 12, '0);

        // R10: pseudo-random traffic, reads in every mode
        phase = "R10";
        s = 32'h1234_5678;
        for (int i = 0; i < 400; i++) begin
            logic [3:0] wa, wb;
            int aa, ab;
            s ^= s << 13; s ^= s >> 17; s ^= s << 5;
            wa = s[1] ? s[7:4] : 4'h0;
            wb = s[2] ? s[11:8] : 4'h0;
            aa = int'(s[16:12]);
            ab = int'(s[21:17]);
            if (aa == ab && wa != 0 && wb != 0) ab = (aa + 1) % 32;
            drive(s[22] | s[23], wa, aa, {s[3:0], s}, s[24] | s[25], wb, ab, {s[31:28], ~s});
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule